// File: doc/BRIEF.md
# UART Variant Probe Sequencer

This block is a small bus master that identifies which generation of PC-style UART sits on a synchronous register bus. A one-clock `start` pulse launches a fixed program of register writes and read-backs. The device is classified by whether the values it returns match a decision tree of echo tests. No identification register is read. When the tree reaches a leaf, the block raises `done` for one clock and presents a 4-bit type code, which it holds until the next accepted start.

Every access takes two clocks. In the first clock a write or read strobe is asserted with its address and data. The second clock is idle, and read data is captured in it. The UART is expected to return read data one clock after the read strobe. A sequence stops as early as the tree allows, so a missing device finishes in 4 accesses and a full classification needs 15.

Top module: `uart_probe_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `bus_wr` and `bus_rd` are 0 and `type_code` is 0. While idle no strobe is issued.
- R2: Each access asserts exactly one of `bus_wr`/`bus_rd` for one clock, followed by one clock with no strobe. A sequence that makes N accesses takes exactly 2N clocks from the start-sampling edge to the edge that raises `done`.
- R3: The presence test writes 0x00 to offset 1, writes 0x80 to offset 3, writes 0x5A to offset 1 and reads offset 1. Any value other than 0x5A ends with code 0. The block then writes 0x00 to offset 3 and reads offset 1. A value of 0x5A ends with code 0 (bank switching broken).
- R4: The block writes 0x5A to offset 7 and reads it back. A mismatch ends with code 1.
- R5: The block writes 0xBF to offset 3 and reads offset 7. A value other than 0x5A ends with code 6.
- R6: The block writes 0x80 to offset 3 and 0xE7 to offset 2, then reads offset 2. Bit 6 clear gives code 2. Otherwise bit 7 clear gives code 3. Otherwise bit 5 set gives code 7. Otherwise the sequence continues.
- R7: The block writes 0x20 to offset 4 and reads it back. Bit 5 set gives code 5, and bit 5 clear gives code 4.
- R8: `done` is high for exactly one clock per sequence. `busy` falls on the same edge that raises `done`. Code 8 and above are never reported.
- R9: A `start` pulse while `busy` is high is ignored. It neither restarts nor lengthens the sequence, and it produces no second `done`.
- R10: `type_code` reads 0 from the accepted start until `done`, then holds its value until the next accepted start.
- R11: Each read decision uses the `bus_rdata` value present in the clock after the read strobe, not the value present during the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request to begin a probe |
| busy | output | 1 | High while a probe sequence runs |
| done | output | 1 | One-clock pulse when the type is known |
| type_code | output | 4 | Detected device type (0..7) |
| bus_addr | output | 3 | Register offset of the current access |
| bus_wdata | output | 8 | Write data of the current access |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid one clock after `bus_rd` |

## Verification
The assertions check the bus protocol on every cycle: strobes never overlap, a strobe is always followed by an idle clock, and no strobe appears while idle. They also check that `done` lasts one clock and that `type_code` stays stable between sequences. Only the bench can show that the decision tree picks the right code and stops after the right number of accesses. For that it sweeps a behavioural UART model over every combination of presence, bank switching, scratch, enhanced-register hiding, FIFO level and flow-control echo. The bench scenarios also show that read data is sampled in the correct clock and that a start pulse during a run has no effect.

// File: rtl/uart_probe_pkg.sv
package uart_probe_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int CODE_W    = 4;
  localparam int NUM_STEPS = 15;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  // Register offsets of the target device (fixed by the device's decode)
  localparam logic [ADDR_W-1:0] OFS_IRQEN = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_DIVHI = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_FIFO  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LINE  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MODEM = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_SCR   = 3'd7;

  localparam logic [DATA_W-1:0] PAT_ECHO  = 8'h5A;
  localparam logic [DATA_W-1:0] PAT_BANK  = 8'h80;
  localparam logic [DATA_W-1:0] PAT_EXT   = 8'hBF;
  localparam logic [DATA_W-1:0] PAT_FIFO  = 8'hE7;
  localparam logic [DATA_W-1:0] PAT_FLOW  = 8'h20;

  // Step positions where a read result is judged
  localparam logic [STEP_W-1:0] CHK_DIV   = 4'd3;
  localparam logic [STEP_W-1:0] CHK_BANK  = 4'd5;
  localparam logic [STEP_W-1:0] CHK_SCR   = 4'd7;
  localparam logic [STEP_W-1:0] CHK_EXT   = 4'd9;
  localparam logic [STEP_W-1:0] CHK_FIFO  = 4'd12;
  localparam logic [STEP_W-1:0] CHK_FLOW  = 4'd14;

  // Result codes
  localparam logic [CODE_W-1:0] TC_ABSENT   = 4'd0;
  localparam logic [CODE_W-1:0] TC_NOSCR    = 4'd1;
  localparam logic [CODE_W-1:0] TC_NOFIFO   = 4'd2;
  localparam logic [CODE_W-1:0] TC_BADFIFO  = 4'd3;
  localparam logic [CODE_W-1:0] TC_FIFO     = 4'd4;
  localparam logic [CODE_W-1:0] TC_FLOW     = 4'd5;
  localparam logic [CODE_W-1:0] TC_EXTREG   = 4'd6;
  localparam logic [CODE_W-1:0] TC_WIDEFIFO = 4'd7;

  typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } step_t;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_STROBE = 2'd1, PH_SETTLE = 2'd2} phase_e;

endpackage

// File: rtl/uart_probe_rom.sv
module uart_probe_rom
  import uart_probe_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);

  always_comb begin
    step = '{op: OP_WR, addr: '0, data: '0};
    case (idx)
      4'd0:  step = '{op: OP_WR, addr: OFS_IRQEN, data: 8'h00};
      4'd1:  step = '{op: OP_WR, addr: OFS_LINE,  data: PAT_BANK};
      4'd2:  step = '{op: OP_WR, addr: OFS_DIVHI, data: PAT_ECHO};
      4'd3:  step = '{op: OP_RD, addr: OFS_DIVHI, data: 8'h00};
      4'd4:  step = '{op: OP_WR, addr: OFS_LINE,  data: 8'h00};
      4'd5:  step = '{op: OP_RD, addr: OFS_IRQEN, data: 8'h00};
      4'd6:  step = '{op: OP_WR, addr: OFS_SCR,   data: PAT_ECHO};
      4'd7:  step = '{op: OP_RD, addr: OFS_SCR,   data: 8'h00};
      4'd8:  step = '{op: OP_WR, addr: OFS_LINE,  data: PAT_EXT};
      4'd9:  step = '{op: OP_RD, addr: OFS_SCR,   data: 8'h00};
      4'd10: step = '{op: OP_WR, addr: OFS_LINE,  data: PAT_BANK};
      4'd11: step = '{op: OP_WR, addr: OFS_FIFO,  data: PAT_FIFO};
      4'd12: step = '{op: OP_RD, addr: OFS_FIFO,  data: 8'h00};
      4'd13: step = '{op: OP_WR, addr: OFS_MODEM, data: PAT_FLOW};
      4'd14: step = '{op: OP_RD, addr: OFS_MODEM, data: 8'h00};
      default: step = '{op: OP_WR, addr: '0, data: '0};
    endcase
  end

endmodule

// File: rtl/uart_probe_judge.sv
module uart_probe_judge
  import uart_probe_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  input  logic [DATA_W-1:0] rdata,
  output logic              finish,
  output logic [CODE_W-1:0] code
);

  logic echo_hit;
  assign echo_hit = (rdata == PAT_ECHO);

  always_comb begin
    finish = 1'b0;
    code   = TC_ABSENT;
    case (idx)
      CHK_DIV: begin
        finish = !echo_hit;
        code   = TC_ABSENT;
      end
      CHK_BANK: begin
        finish = echo_hit;
        code   = TC_ABSENT;
      end
      CHK_SCR: begin
        finish = !echo_hit;
        code   = TC_NOSCR;
      end
      CHK_EXT: begin
        finish = !echo_hit;
        code   = TC_EXTREG;
      end
      CHK_FIFO: begin
        if (!rdata[6]) begin
          finish = 1'b1;
          code   = TC_NOFIFO;
        end else if (!rdata[7]) begin
          finish = 1'b1;
          code   = TC_BADFIFO;
        end else if (rdata[5]) begin
          finish = 1'b1;
          code   = TC_WIDEFIFO;
        end
      end
      CHK_FLOW: begin
        finish = 1'b1;
        code   = rdata[5] ? TC_FLOW : TC_FIFO;
      end
      default: begin
        finish = 1'b0;
        code   = TC_ABSENT;
      end
    endcase
  end

endmodule

// File: rtl/uart_probe_seq.sv
module uart_probe_seq
  import uart_probe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] type_code,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  phase_e            phase_q, phase_n;
  logic [STEP_W-1:0] idx_q, idx_n;
  logic              done_q, done_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic              code_en;

  step_t             cur_step;
  logic              verdict_fin;
  logic [CODE_W-1:0] verdict_code;

  uart_probe_rom u_rom (
    .idx  (idx_q),
    .step (cur_step)
  );

  uart_probe_judge u_judge (
    .idx    (idx_q),
    .rdata  (bus_rdata),
    .finish (verdict_fin),
    .code   (verdict_code)
  );

  // Next-state logic
  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q;
    done_n  = 1'b0;
    code_n  = code_q;
    code_en = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_n = PH_STROBE;
          idx_n   = '0;
          code_n  = TC_ABSENT;
          code_en = 1'b1;
        end
      end
      PH_STROBE: begin
        phase_n = PH_SETTLE;
      end
      PH_SETTLE: begin
        if ((cur_step.op == OP_RD) && verdict_fin) begin
          phase_n = PH_IDLE;
          done_n  = 1'b1;
          code_n  = verdict_code;
          code_en = 1'b1;
        end else if (idx_q == LAST_STEP) begin
          phase_n = PH_IDLE;
          done_n  = 1'b1;
          code_n  = TC_ABSENT;
          code_en = 1'b1;
        end else begin
          phase_n = PH_STROBE;
          idx_n   = idx_q + 1'b1;
        end
      end
      default: begin
        phase_n = PH_IDLE;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= TC_ABSENT;
    end else if (code_en) begin
      code_q <= code_n;
    end
  end

  // Bus drive
  logic strobe_cycle;
  assign strobe_cycle = (phase_q == PH_STROBE);

  assign bus_wr    = strobe_cycle && (cur_step.op == OP_WR);
  assign bus_rd    = strobe_cycle && (cur_step.op == OP_RD);
  assign bus_addr  = strobe_cycle ? cur_step.addr : '0;
  assign bus_wdata = bus_wr ? cur_step.data : '0;

  assign busy      = (phase_q != PH_IDLE);
  assign done      = done_q;
  assign type_code = code_q;

  // Assertions
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));                                               // R2
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> !(bus_wr || bus_rd));                       // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_wr || bus_rd));                                    // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                   // R8
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (type_code <= TC_WIDEFIFO));                              // R8
  AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(type_code));                         // R10
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(phase_q == PH_SETTLE)) |=> busy);                       // R9

endmodule

// File: tb/uart_probe_seq_tb.sv
module uart_probe_seq_tb;
  import uart_probe_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic              busy;
  logic              done;
  logic [CODE_W-1:0] type_code;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_wr;
  logic              bus_rd;
  logic [DATA_W-1:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  uart_probe_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .type_code (type_code),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural target model
  logic       m_present, m_bank, m_scr, m_ext, m_flow, m_clr;
  logic [1:0] m_fifo;
  logic [7:0] r_ier, r_line, r_div, r_scr, r_modem, r_fctl;

  function automatic logic [7:0] model_read(input logic [2:0] a);
    logic [7:0] v;
    v = 8'hFF;
    if (m_present) begin
      case (a)
        3'd1: v = (m_bank && r_line[7]) ? r_div : r_ier;
        3'd2: begin
          case (m_fifo)
            2'd0: v = 8'h01;
            2'd1: v = 8'h41;
            2'd2: v = 8'hC1;
            default: v = 8'hC1 | (r_fctl & 8'h20);
          endcase
        end
        3'd3: v = r_line;
        3'd4: v = r_modem;
        3'd7: v = !m_scr ? 8'hFF : ((m_ext && r_line == 8'hBF) ? 8'h00 : r_scr);
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (m_clr) begin
      r_ier <= 8'h00; r_line <= 8'h00; r_div <= 8'h00;
      r_scr <= 8'h00; r_modem <= 8'h00; r_fctl <= 8'h00;
      bus_rdata <= 8'h00;
    end else begin
      if (bus_rd) bus_rdata <= model_read(bus_addr);
      else        bus_rdata <= 8'h33;   // stale value outside the capture clock
      if (bus_wr) begin
        case (bus_addr)
          3'd1: if (m_bank && r_line[7]) r_div <= bus_wdata; else r_ier <= bus_wdata;
          3'd2: r_fctl <= bus_wdata;
          3'd3: r_line <= bus_wdata;
          3'd4: r_modem <= m_flow ? bus_wdata : (bus_wdata & 8'hDF);
          3'd7: r_scr <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // Expected result from the requirements
  function automatic int exp_code();
    if (!m_present || !m_bank) return 0;
    if (!m_scr) return 1;
    if (m_ext) return 6;
    if (m_fifo == 2'd0) return 2;
    if (m_fifo == 2'd1) return 3;
    if (m_fifo == 2'd3) return 7;
    return m_flow ? 5 : 4;
  endfunction

  function automatic int exp_accesses();
    if (!m_present) return 4;
    if (!m_bank) return 6;
    if (!m_scr) return 8;
    if (m_ext) return 10;
    if (m_fifo != 2'd2) return 13;
    return 15;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_probe(input bit poke_busy);
    int  ecode, nacc, seen_at, strobes, dones;
    logic [CODE_W-1:0] held;
    ecode   = exp_code();
    nacc    = exp_accesses();
    seen_at = -1;
    strobes = 0;
    dones   = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int i = 1; i <= 60; i++) begin
      if (i == 1) check(type_code == 4'd0, "R10 code cleared on start", int'(type_code), 0);
      if (bus_wr || bus_rd) strobes++;
      if (bus_wr && bus_rd) check(1'b0, "R2 dual strobe", 1, 0);
      if (poke_busy && i == 3) start = 1'b1;
      if (poke_busy && i == 4) start = 1'b0;
      @(negedge clk);
      if (done) begin
        seen_at = i;
        break;
      end
    end
    start = 1'b0;
    check(seen_at == 2 * nacc, "R2 R9 sequence length", seen_at, 2 * nacc);
    check(int'(type_code) == ecode, "R3 R4 R5 R6 R7 R11 type", int'(type_code), ecode);
    check(strobes == nacc, "R2 strobe count", strobes, nacc);
    check(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    held = type_code;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      if (done) dones++;
      if (bus_wr || bus_rd) check(1'b0, "R1 strobe while idle", 1, 0);
    end
    check(dones == 0, "R8 R9 single done", dones, 0);
    check(type_code == held, "R10 type holds", int'(type_code), int'(held));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    m_clr = 1'b1;
    m_present = 1'b1; m_bank = 1'b1; m_scr = 1'b1;
    m_ext = 1'b0; m_fifo = 2'd2; m_flow = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(type_code == 4'd0, "R1 type", int'(type_code), 0);
    check(!(bus_wr || bus_rd), "R1 strobes", int'(bus_wr | bus_rd), 0);
    start = 1'b1;   // held during reset: must not start anything
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b1;
    m_clr = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

    for (int c = 0; c < 128; c++) begin
      m_clr = 1'b1;
      @(negedge clk);
      m_clr = 1'b0;
      m_present = c[0];
      m_bank    = c[1];
      m_scr     = c[2];
      m_ext     = c[3];
      m_fifo    = c[5:4];
      m_flow    = c[6];
      run_probe(c[0] ^ c[4]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule